// File: doc/BRIEF.md
# Selectable-Order Four-Beat Burst Address Generator

This block supplies the address for every access of a four-beat burst. A load cycle captures a full external address as the burst start. Each later advance cycle steps only the two lowest address bits, while the upper bits stay frozen. A static order input picks one of two sequences. Interleaved order flips low bits with an exclusive-or against the beat number. Linear order counts upward and wraps inside the four-entry block. An active-high hold input stalls everything, so the address and the beat position keep their values.

The control is a small state machine with two states. `ST_IDLE` is the state after reset, before any burst has been loaded, and the address reads zero. `ST_BURST` is the state after at least one load. The transitions are: `ST_IDLE -> ST_BURST` on a load; `ST_BURST -> ST_BURST` on a load, which restarts the beat count at zero; `ST_BURST -> ST_BURST` on an advance, which increments the beat count. An advance in `ST_IDLE`, and any cycle with hold high, leaves the state, the beat count and the address unchanged.

Top module: `bag_burst_addr_gen`

## Requirements
- R1: After reset, `addr_o` is all zeros.
- R2: A clock edge with `hold_i` low and `adv_i` low loads `ext_addr_i`. From that edge on, `addr_o` equals the loaded value.
- R3: A clock edge with `hold_i` low and `adv_i` high, after a load, ignores `ext_addr_i` and moves to the next beat. This changes the low two bits of `addr_o`.
- R4: With `order_i` high (interleaved), beat n (n = 0..3) has low bits equal to the start's low two bits XOR n.
- R5: With `order_i` low (linear), beat n has low bits equal to (start's low two bits + n) mod 4.
- R6: After the fourth beat, one more advance returns the low bits to the start's low bits, and the sequence repeats.
- R7: Address bits above bit 1 never change on an advance.
- R8: A clock edge with `hold_i` high changes nothing, whatever `adv_i` and `ext_addr_i` are. The beat position is also kept, so the next advance continues the sequence.
- R9: A load in the middle of a burst resets the beat count to zero, and the new start address is output.
- R10: Advance cycles before the first load leave `addr_o` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_i | input | 1 | High stalls the block: no load and no advance |
| adv_i | input | 1 | Low loads `ext_addr_i`; high advances the beat |
| ext_addr_i | input | ADDR_W | External start address |
| order_i | input | 1 | High selects interleaved order; low selects linear order |
| addr_o | output | ADDR_W | Address for the current beat |

## Verification
The assertions assume that `order_i` changes only while the beat count is zero, that is, right after a reset or a load. Only then does the combinational low-bit output stay the same across a mode change, which the stall property depends on. The stimulus respects this rule. Before every change of order it issues a load with the old order, and it changes the order only together with the next load. All other inputs, including junk values on `ext_addr_i` during advance and hold cycles, vary freely.

// File: rtl/bag_pkg.sv
package bag_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bag_state_e;

    typedef enum logic [0:0] {
        ORD_LINEAR      = 1'b0,
        ORD_INTERLEAVED = 1'b1
    } bag_order_e;
endpackage

// File: rtl/bag_step_calc.sv
module bag_step_calc #(
    parameter int LOW_W = 2
) (
    input  logic [LOW_W-1:0] start_i,
    input  logic [LOW_W-1:0] beat_i,
    input  logic             order_i,
    output logic [LOW_W-1:0] low_o
);
    logic [LOW_W-1:0] xor_low;
    logic [LOW_W-1:0] add_low;

    // Interleaved order: flip each start bit where the beat number has a one.
    for (genvar b = 0; b < LOW_W; b++) begin : g_xor_bit
        assign xor_low[b] = start_i[b] ^ beat_i[b];
    end

    // Linear order: the sum wraps naturally inside LOW_W bits.
    assign add_low = start_i + beat_i;

    always_comb begin
        if (order_i == bag_pkg::ORD_INTERLEAVED) begin
            low_o = xor_low;
        end else begin
            low_o = add_low;
        end
    end
endmodule

// File: rtl/bag_ctrl.sv
module bag_ctrl
    import bag_pkg::*;
#(
    parameter int LOW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             adv_i,
    output bag_state_e       state_o,
    output logic [LOW_W-1:0] beat_o,
    output logic             load_o
);
    bag_state_e       state_q, state_d;
    logic [LOW_W-1:0] beat_q, beat_d;
    logic             step;

    // Next-state and strobe process.
    always_comb begin
        load_o  = !hold_i && !adv_i;
        step    = !hold_i && adv_i;
        state_d = state_q;
        beat_d  = beat_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_o) begin
                    state_d = ST_BURST;
                    beat_d  = '0;
                end
            end
            ST_BURST: begin
                if (load_o) begin
                    beat_d = '0;
                end else if (step) begin
                    beat_d = beat_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                beat_d  = '0;
            end
        endcase
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    assign state_o = state_q;
    assign beat_o  = beat_q;
endmodule

// File: rtl/bag_burst_addr_gen.sv
module bag_burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] ext_addr_i,
    input  logic              order_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int LOW_W = $clog2(BURST_LEN);
    localparam int UP_W  = ADDR_W - LOW_W;

    bag_state_e       state;
    logic [LOW_W-1:0] beat;
    logic             load;
    logic [UP_W-1:0]  upper_q;
    logic [LOW_W-1:0] start_q;
    logic [LOW_W-1:0] low_now;

    bag_ctrl #(.LOW_W(LOW_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (hold_i),
        .adv_i   (adv_i),
        .state_o (state),
        .beat_o  (beat),
        .load_o  (load)
    );

    // Start-address register, written only on a load.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
        end else if (load) begin
            upper_q <= ext_addr_i[ADDR_W-1:LOW_W];
            start_q <= ext_addr_i[LOW_W-1:0];
        end
    end

    bag_step_calc #(.LOW_W(LOW_W)) u_calc (
        .start_i (start_q),
        .beat_i  (beat),
        .order_i (order_i),
        .low_o   (low_now)
    );

    // Output process.
    always_comb begin
        unique case (state)
            ST_IDLE:  addr_o = '0;
            ST_BURST: addr_o = {upper_q, low_now};
            default:  addr_o = '0;
        endcase
    end
endmodule

// File: rtl/bag_checker.sv
module bag_checker #(
    parameter int ADDR_W = 16,
    parameter int LOW_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold_i,
    input logic              adv_i,
    input logic [ADDR_W-1:0] ext_addr_i,
    input logic [ADDR_W-1:0] addr_o
);
    logic seen_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_load <= 1'b0;
        end else if (!hold_i && !adv_i) begin
            seen_load <= 1'b1;
        end
    end

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !adv_i) |=> (addr_o == $past(ext_addr_i)));

    assert_step_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && adv_i && seen_load) |=>
            (addr_o[LOW_W-1:0] != $past(addr_o[LOW_W-1:0])));

    assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && adv_i) |=>
            (addr_o[ADDR_W-1:LOW_W] == $past(addr_o[ADDR_W-1:LOW_W])));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(addr_o));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_load |-> (addr_o == '0));
endmodule

bind bag_burst_addr_gen bag_checker #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_bag_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_i     (hold_i),
    .adv_i      (adv_i),
    .ext_addr_i (ext_addr_i),
    .addr_o     (addr_o)
);

// File: tb/tb_bag_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_bag_burst_addr_gen;
    localparam int AW = 16;

    typedef struct {
        logic [AW-1:0] exp;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hold_i = 1'b0;
    logic          adv_i = 1'b1;
    logic [AW-1:0] ext_addr_i = '0;
    logic          order_i = 1'b1;
    logic [AW-1:0] addr_o;

    int checks = 0;
    int failures = 0;
    item_t sb[$];

    // reference model state
    bit            m_loaded = 0;
    logic [AW-3:0] m_upper = '0;
    logic [1:0]    m_start = '0;
    logic [1:0]    m_beat = '0;

    always #5 clk = ~clk;

    bag_burst_addr_gen #(.ADDR_W(AW), .BURST_LEN(4)) dut (
        .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .adv_i(adv_i),
        .ext_addr_i(ext_addr_i), .order_i(order_i), .addr_o(addr_o)
    );

    function automatic logic [AW-1:0] model_addr();
        logic [1:0] lo;
        if (!m_loaded) return '0;
        lo = order_i ? (m_start ^ m_beat) : 2'(m_start + m_beat);
        return {m_upper, lo};
    endfunction

    task automatic drive(input bit adv, input bit hold, input logic [AW-1:0] ext,
                         input bit ord, input string tag);
        item_t it;
        @(negedge clk);
        adv_i = adv; hold_i = hold; ext_addr_i = ext; order_i = ord;
        if (!hold) begin
            if (!adv) begin
                m_loaded = 1; m_upper = ext[AW-1:2]; m_start = ext[1:0]; m_beat = 0;
            end else if (m_loaded) begin
                m_beat = m_beat + 1;
            end
        end
        it.exp = model_addr();
        it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (addr_o !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, addr_o, it.exp);
                end
            end
        end
    end

    bit finished = 0;
    initial begin
        #2000000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #23;
        checks++;
        if (addr_o !== '0) begin
            failures++;
            $display("FAIL R1 actual=%h expected=%h", addr_o, 16'h0);
        end
        rst_n = 1'b1;

        // R10: advances before any load
        drive(1, 0, 16'hFFFF, 1, "R10");
        drive(1, 0, 16'h5A5A, 1, "R10");

        // R4 R6 R7 R3: interleaved from low bits 2'b10
        drive(0, 0, 16'h1232, 1, "R2");
        for (int i = 0; i < 4; i++) drive(1, 0, 16'hBEEF + 16'(i), 1, "R4 R3 R7");
        drive(1, 0, 16'h0000, 1, "R6");

        // switch to linear: load first, then change order on a fresh load
        drive(0, 0, 16'h4561, 1, "R2");
        drive(0, 0, 16'h4561, 0, "R2");
        for (int i = 0; i < 4; i++) drive(1, 0, 16'hFFFF, 0, "R5 R7");
        drive(1, 0, 16'h1111, 0, "R6");

        // R8: stall holds address and beat, ignores load
        drive(1, 0, 16'h0000, 0, "R5");
        drive(0, 1, 16'h9999, 0, "R8");
        drive(1, 1, 16'h7777, 0, "R8");
        drive(1, 0, 16'h3333, 0, "R8");

        // R9: reload mid-burst
        drive(0, 0, 16'hABCF, 0, "R2");
        drive(1, 0, 16'h0000, 0, "R5");
        drive(0, 0, 16'h00F2, 0, "R9");
        drive(1, 0, 16'h0000, 0, "R9");

        // linear from every start
        for (int s = 0; s < 4; s++) begin
            drive(0, 0, 16'h2C40 | 16'(s), 0, "R2");
            for (int n = 0; n < 5; n++) drive(1, 0, 16'hA5A5, 0, "R5 R6");
        end
        // interleaved from every start
        drive(0, 0, 16'h0001, 0, "R2");
        drive(0, 0, 16'h0001, 1, "R2");
        for (int s = 0; s < 4; s++) begin
            drive(0, 0, 16'h7E00 | 16'(s), 1, "R2");
            for (int n = 0; n < 5; n++) drive(1, 0, 16'h5A5A, 1, "R4 R6");
        end

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule